// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master that a processor controls through four word-wide registers. The registers are a control/status word, a clock divider, a slave-select word and a data port. Software stores the word to send, picks the serial format and writes the control word with its go bit set. The block then runs one or more words on the serial lines. The go bit reads back as a busy flag while the transfer is in progress. When the transfer ends, the block sets a sticky completion flag that can drive an interrupt line.

The serial format is fully programmable. Software sets the word length from 1 to 32 bits, the bit order, the clock idle level, and the clock edge used to drive data and the edge used to capture it, each chosen separately. It also sets a burst of one to four words and an idle gap of whole clock periods between the words of a burst. The one slave-select output is controlled directly by software.

Top module: `spi_reg_master`

## Requirements
- R1: After reset every register reads zero. `sclk`, `irq` and `mosi` are low, and `ssOut` is high (deselected, with the active level low).
- R2: Register offsets are 0x00 control/status, 0x04 divider (bits 15:0), 0x08 slave select and 0x10 data. Control bits are: 0 go/busy, 1 capture on falling edge, 2 drive on falling edge, 7:3 word length, 9:8 words minus one, 10 LSB first, 15:12 gap, 16 done, 17 interrupt enable, 31 clock idle level. All other bits read zero. A read at 0x10 returns the received word, not the transmit word.
- R3: Each word sends the transmit register on `mosi`. A length field of L sends L bits, and 0 sends 32 bits. Bit L-1 goes first, or bit 0 goes first when LSB-first is set.
- R4: The received word reads back with its first bit at position L-1, or at position 0 in LSB-first mode, and with every bit above L-1 equal to zero. It holds the last word of the burst.
- R5: `sclk` rests at the idle level bit while no transfer is running. Data is captured on the falling `sclk` edge when control bit 1 is set and on the rising edge when it is clear. Each new bit is driven on the edge chosen by control bit 2, as the first such edge after the previous bit was captured; when both bits pick the same edge, the new bit is driven on the capture edge itself, just after the capture.
- R6: Each `sclk` half-period lasts divider+1 clock cycles. A transfer keeps the block busy for W·(1+2L(D+1)) + (W−1)·2G(D+1) cycles from the go write, where W is the word count, L the length, D the divider and G the gap. Busy then reads zero.
- R7: A burst sends count+1 words, each from the same transmit register, with G idle `sclk` periods between consecutive words.
- R8: The done flag sets on the cycle busy clears. Writing the control word with bit 16 set clears the flag, and writing it with bit 16 clear leaves the flag unchanged. `irq` is the flag ANDed with the enable bit.
- R9: While busy, writes to the control fields, the go bit, the divider and the transmit register are ignored.
- R10: `ssOut` equals the active level (slave-select bit 2) when bit 0 is set and its inverse otherwise. It changes on the cycle after the write and does not depend on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssOut | output | 1 | Slave-select output |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Readback, `ssOut` and `irq` are therefore checked at the following falling clock edge. The `sclk` idle level follows a polarity change one edge later, so that check waits a second cycle. During a transfer the bench runs a slave model on every falling clock edge. It captures `mosi` as it stood before the capture-type `sclk` edge, and it presents the next `miso` bit right after that edge, so the master sees the new bit at least one cycle before its next capture. Busy is counted cycle by cycle against the R6 formula. The received word, the done flag and `irq` are checked only once busy has dropped.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = $clog2(REG_W);
  localparam int CNT_W   = IDX_W + 2;
  localparam int WCNT_W  = 2;
  localparam int GAP_W   = 4;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_DIV  = 'h04;
  localparam int OFS_SEL  = 'h08;
  localparam int OFS_DATA = 'h10;

  localparam int B_GO    = 0;
  localparam int B_RXNEG = 1;
  localparam int B_TXNEG = 2;
  localparam int B_LEN   = 3;
  localparam int B_WCNT  = 8;
  localparam int B_LSB   = 10;
  localparam int B_GAP   = 12;
  localparam int B_DONE  = 16;
  localparam int B_IEN   = 17;
  localparam int B_CPOL  = 31;
  localparam int B_SSON  = 0;
  localparam int B_SSLEV = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} seqState_t;

  typedef struct packed {
    logic             startWord;
    logic             launch;
    logic [IDX_W-1:0] launchIdx;
    logic             sample;
    logic [IDX_W-1:0] sampleIdx;
  } shiftStrobe_t;
endpackage

// File: rtl/spi_reg_shift.sv
`timescale 1ns/1ps
module spi_reg_shift
  import spi_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobe_t     strb,
  input  logic             lsbFirst,
  input  logic [IDX_W-1:0] bitLen,
  input  logic [REG_W-1:0] txWord,
  input  logic             miso,
  output logic             mosi,
  output logic [REG_W-1:0] rxWord
);
  logic [IDX_W:0]   wordLen;
  logic [IDX_W-1:0] firstPos, launchPos, samplePos;

  function automatic logic [IDX_W-1:0] mapPos(input logic [IDX_W-1:0] idx,
                                              input logic lsb,
                                              input logic [IDX_W:0] len);
    return lsb ? idx : IDX_W'(len - (IDX_W+1)'(1) - {1'b0, idx});
  endfunction

  assign wordLen   = (bitLen == '0) ? (IDX_W+1)'(REG_W) : {1'b0, bitLen};
  assign firstPos  = mapPos('0, lsbFirst, wordLen);
  assign launchPos = mapPos(strb.launchIdx, lsbFirst, wordLen);
  assign samplePos = mapPos(strb.sampleIdx, lsbFirst, wordLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosi   <= 1'b0;
      rxWord <= '0;
    end else begin
      if (strb.startWord) begin
        mosi   <= txWord[firstPos];
        rxWord <= '0;
      end
      if (strb.launch) mosi <= txWord[launchPos];
      if (strb.sample) rxWord[samplePos] <= miso;
    end
  end
endmodule

// File: rtl/spi_reg_ctrl.sv
`timescale 1ns/1ps
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  rxWord,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  txWord,
  output logic              lsbFirst,
  output logic [IDX_W-1:0]  bitLen,
  output shiftStrobe_t      strb,
  output logic              busy,
  output logic              cpol,
  output logic              doneFlag,
  output logic              sclk,
  output logic              ssOut,
  output logic              irq
);
  logic              rxNeg, txNeg, intEn, ssEn, ssLev;
  logic [WCNT_W-1:0] wordCnt, wordIdx;
  logic [GAP_W-1:0]  gapLen;
  logic [DIV_W-1:0]  divVal, divCnt;
  logic [CNT_W-1:0]  edgeCnt, wordLen, launchBit;
  seqState_t         state;
  logic              ctrlWr, divWr, selWr, dataWr, goReq;
  logic              halfEnd, lastEdge, gapLast, finish, inEdge;
  logic              sampleIsMid, launchIsMid, edgeIsMid;
  logic [REG_W-1:0]  ctrlWord;
  logic              unusedBits;

  assign ctrlWr = wrEn && (addr == ADDR_W'(OFS_CTRL));
  assign divWr  = wrEn && (addr == ADDR_W'(OFS_DIV));
  assign selWr  = wrEn && (addr == ADDR_W'(OFS_SEL));
  assign dataWr = wrEn && (addr == ADDR_W'(OFS_DATA));
  assign goReq  = ctrlWr && !busy && wrData[B_GO];
  assign unusedBits = ^{wrData[11], wrData[30:18]};

  // Edge bookkeeping: edge e ends half e; even edges sit mid-slot.
  assign wordLen     = (bitLen == '0) ? CNT_W'(REG_W) : CNT_W'(bitLen);
  assign halfEnd     = (divCnt == divVal);
  assign lastEdge    = (edgeCnt == ((wordLen << 1) - CNT_W'(1)));
  assign gapLast     = (edgeCnt == (CNT_W'({gapLen, 1'b0}) - CNT_W'(1)));
  assign sampleIsMid = (rxNeg == cpol);
  assign launchIsMid = (txNeg == cpol);
  assign edgeIsMid   = ~edgeCnt[0];
  assign launchBit   = (launchIsMid == sampleIsMid) ? (edgeCnt >> 1) + CNT_W'(1)
                                                    : (edgeCnt + CNT_W'(1)) >> 1;
  assign inEdge      = (state == ST_SHIFT) && halfEnd;
  assign finish      = inEdge && lastEdge && (wordIdx == wordCnt);

  always_comb begin
    strb           = '0;
    strb.startWord = (state == ST_LOAD);
    strb.sample    = inEdge && (edgeIsMid == sampleIsMid);
    strb.sampleIdx = IDX_W'(edgeCnt >> 1);
    strb.launch    = inEdge && (edgeIsMid == launchIsMid) && (launchBit < wordLen);
    strb.launchIdx = IDX_W'(launchBit);
  end

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {cpol, intEn, lsbFirst, txNeg, rxNeg} <= '0;
      bitLen <= '0; wordCnt <= '0; gapLen <= '0;
      divVal <= '0; txWord <= '0; ssEn <= 1'b0; ssLev <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (ctrlWr && !busy) begin
        cpol     <= wrData[B_CPOL];
        intEn    <= wrData[B_IEN];
        gapLen   <= wrData[B_GAP +: GAP_W];
        lsbFirst <= wrData[B_LSB];
        wordCnt  <= wrData[B_WCNT +: WCNT_W];
        bitLen   <= wrData[B_LEN +: IDX_W];
        txNeg    <= wrData[B_TXNEG];
        rxNeg    <= wrData[B_RXNEG];
      end
      if (divWr && !busy)  divVal <= wrData[DIV_W-1:0];
      if (dataWr && !busy) txWord <= wrData;
      if (selWr) begin
        ssEn  <= wrData[B_SSON];
        ssLev <= wrData[B_SSLEV];
      end
      if (finish)                       doneFlag <= 1'b1;
      else if (ctrlWr && wrData[B_DONE]) doneFlag <= 1'b0;
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; busy <= 1'b0; sclk <= 1'b0;
      divCnt <= '0; edgeCnt <= '0; wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (goReq) begin
            busy    <= 1'b1;
            wordIdx <= '0;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          sclk    <= cpol;
          divCnt  <= '0;
          edgeCnt <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (halfEnd) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (lastEdge) begin
              edgeCnt <= '0;
              if (wordIdx == wordCnt) begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                wordIdx <= wordIdx + WCNT_W'(1);
                state   <= (gapLen == '0) ? ST_LOAD : ST_GAP;
              end
            end else begin
              edgeCnt <= edgeCnt + CNT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (halfEnd) begin
            divCnt <= '0;
            if (gapLast) begin
              edgeCnt <= '0;
              state   <= ST_LOAD;
            end else begin
              edgeCnt <= edgeCnt + CNT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlWord                    = '0;
    ctrlWord[B_GO]              = busy;
    ctrlWord[B_RXNEG]           = rxNeg;
    ctrlWord[B_TXNEG]           = txNeg;
    ctrlWord[B_LEN +: IDX_W]    = bitLen;
    ctrlWord[B_WCNT +: WCNT_W]  = wordCnt;
    ctrlWord[B_LSB]             = lsbFirst;
    ctrlWord[B_GAP +: GAP_W]    = gapLen;
    ctrlWord[B_DONE]            = doneFlag;
    ctrlWord[B_IEN]             = intEn;
    ctrlWord[B_CPOL]            = cpol;
    rdData = '0;
    if (addr == ADDR_W'(OFS_CTRL))      rdData = ctrlWord;
    else if (addr == ADDR_W'(OFS_DIV))  rdData = REG_W'(divVal);
    else if (addr == ADDR_W'(OFS_SEL)) begin
      rdData[B_SSON]  = ssEn;
      rdData[B_SSLEV] = ssLev;
    end
    else if (addr == ADDR_W'(OFS_DATA)) rdData = rxWord;
  end

  assign ssOut = ssEn ? ssLev : ~ssLev;
  assign irq   = doneFlag & intEn;
endmodule

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ssOut,
  output logic              irq
);
  shiftStrobe_t     strb;
  logic [REG_W-1:0] txWord, rxWord;
  logic [IDX_W-1:0] bitLen;
  logic             lsbFirst, busy, cpol, doneFlag;

  spi_reg_ctrl #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) ctrlU (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rxWord(rxWord), .rdData(rdData), .txWord(txWord), .lsbFirst(lsbFirst),
    .bitLen(bitLen), .strb(strb), .busy(busy), .cpol(cpol),
    .doneFlag(doneFlag), .sclk(sclk), .ssOut(ssOut), .irq(irq)
  );

  spi_reg_shift shiftU (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirst(lsbFirst),
    .bitLen(bitLen), .txWord(txWord), .miso(miso), .mosi(mosi),
    .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_reg_master_chk.sv
`timescale 1ns/1ps
module spi_reg_master_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              cpol,
  input logic              sclk,
  input logic              mosi,
  input logic              doneFlag,
  input logic [IDX_W-1:0]  bitLen,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic              ssOut
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sclk == cpol)); // R5

  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(mosi)); // R3

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(bitLen)); // R9

  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_SEL)) |=>
      (ssOut == ($past(wrData[B_SSON]) ~^ $past(wrData[B_SSLEV])))); // R10
endmodule

bind spi_reg_master spi_reg_master_chk #(.ADDR_W(ADDR_W)) chkU (
  .clk(clk), .rstN(rstN), .busy(busy), .cpol(cpol), .sclk(sclk),
  .mosi(mosi), .doneFlag(doneFlag), .bitLen(bitLen), .wrEn(wrEn),
  .addr(addr), .wrData(wrData), .ssOut(ssOut)
);

// File: tb/spi_reg_master_test.sv
`timescale 1ns/1ps
module spi_reg_master_test;
  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, miso = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  wire  [31:0] rdData;
  wire         sclk, mosi, ssOut, irq;
  int          errs = 0, checks = 0;

  spi_reg_master uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .miso(miso), .sclk(sclk), .mosi(mosi),
    .ssOut(ssOut), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  function automatic logic [31:0] mkCtrl(input bit cp, ie, input logic [3:0] gap,
      input bit lsb, input logic [1:0] cnt, input logic [4:0] len,
      input bit txn, rxn, clr, go);
    logic [31:0] w = '0;
    w[31] = cp; w[17] = ie; w[16] = clr; w[15:12] = gap; w[10] = lsb;
    w[9:8] = cnt; w[7:3] = len; w[2] = txn; w[1] = rxn; w[0] = go;
    return w;
  endfunction

  function automatic int expCycles(input int w, l, d, g);
    return w * (1 + 2 * l * (d + 1)) + (w - 1) * 2 * g * (d + 1);
  endfunction

  task automatic runXfer(input bit cp, ie, input logic [3:0] gap, input bit lsb,
      input logic [1:0] cnt, input logic [4:0] len, input bit txn, rxn,
      input logic [15:0] dv, input logic [31:0] txw, slw, input bit meddle);
    int L = (len == 0) ? 32 : int'(len);
    int W = int'(cnt) + 1;
    int k = 0, cyc = 0, bad = 0;
    bit fin = 0, busyNow, prevS, prevM;
    logic [31:0] mask, cap, rdv;
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
    cap = '0;
    wr(8'h04, {16'h0, dv});
    wr(8'h10, txw);
    wr(8'h00, mkCtrl(cp, ie, gap, lsb, cnt, len, txn, rxn, 1'b1, 1'b0));
    @(negedge clk);
    miso  = lsb ? slw[0] : slw[L-1];
    prevS = sclk; prevM = mosi;
    addr = 8'h00; wrData = mkCtrl(cp, ie, gap, lsb, cnt, len, txn, rxn, 1'b0, 1'b1);
    wrEn = 1'b1;
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      wrEn = 1'b0; addr = 8'h00;
      if (meddle && cyc == 2) begin addr = 8'h04; wrData = {16'h0, dv + 16'd7}; wrEn = 1'b1; end
      if (meddle && cyc == 3) begin
        addr = 8'h00; wrEn = 1'b1;
        wrData = mkCtrl(!cp, ie, gap + 4'd1, !lsb, cnt + 2'd1, len + 5'd1, !txn, !rxn, 1'b0, 1'b1);
      end
      if (meddle && cyc == 4) begin addr = 8'h10; wrData = ~txw; wrEn = 1'b1; end
      #1;
      busyNow = (addr != 8'h00) ? 1'b1 : rdData[0];
      if (sclk != prevS && sclk == !rxn) begin
        int bi = k % L;
        cap[lsb ? bi : L - 1 - bi] = prevM;
        k++;
        if (k % L == 0) begin
          if (cap != (txw & mask)) bad++;
          cap = '0;
        end
        miso = lsb ? slw[k % L] : slw[L - 1 - (k % L)];
      end
      prevS = sclk; prevM = mosi;
      if (busyNow) cyc++; else fin = 1;
    end
    wrEn = 1'b0;
    check(cyc == expCycles(W, L, int'(dv), int'(gap)), "R6/R7 busy duration",
          cyc, expCycles(W, L, int'(dv), int'(gap)));
    check(bad == 0 && k == L * W, "R3/R5 mosi words and edge count", k, L * W);
    rd(8'h10, rdv);
    check(rdv == (slw & mask), "R4 received word", rdv, slw & mask);
    rd(8'h00, rdv);
    check(rdv[16] == 1'b1, "R8 done flag set", rdv[16], 1);
    check(irq == ie, "R8 irq follows enable", irq, ie);
    if (meddle) begin
      rd(8'h04, rdv);
      check(rdv == {16'h0, dv}, "R9 divider kept", rdv, {16'h0, dv});
      rd(8'h00, rdv);
      check(rdv[7:3] == len && rdv[31] == cp, "R9 control kept", rdv,
            mkCtrl(cp, ie, gap, lsb, cnt, len, txn, rxn, 1'b1, 1'b0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R6 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); check(v == 0, "R1 control reset", v, 0);
    rd(8'h04, v); check(v == 0, "R1 divider reset", v, 0);
    rd(8'h08, v); check(v == 0, "R1 select reset", v, 0);
    rd(8'h10, v); check(v == 0, "R1 data reset", v, 0);
    check({sclk, irq, mosi} == 3'b000, "R1 outputs low", {sclk, irq, mosi}, 0);
    check(ssOut == 1'b1, "R1 slave deselected", ssOut, 1);

    // R2 layout and readback
    wr(8'h00, 32'h8002_B2F6);
    rd(8'h00, v); check(v == (32'h8002_B2F6 & 32'h8002_F7FE), "R2 control readback", v, 32'h8002_B2F6);
    @(negedge clk);
    check(sclk == 1'b1, "R5 idle level follows polarity", sclk, 1);
    wr(8'h10, 32'hAAAA_5555);
    rd(8'h10, v); check(v == 0, "R2 data read returns receive word", v, 0);
    wr(8'h04, 32'hFFFF_1234);
    rd(8'h04, v); check(v == 32'h0000_1234, "R2 divider width", v, 32'h1234);

    // R10 slave select
    wr(8'h08, 32'h1); check(ssOut == 1'b0, "R10 active low asserted", ssOut, 0);
    wr(8'h08, 32'h5); check(ssOut == 1'b1, "R10 active high asserted", ssOut, 1);
    wr(8'h08, 32'h4); check(ssOut == 1'b0, "R10 active high released", ssOut, 0);

    // Directed transfers
    runXfer(0, 1, 4'd0, 0, 2'd0, 5'd8,  1, 0, 16'd1, 32'h0000_00A5, 32'h0000_003C, 0);
    // R8 write-one-to-clear
    wr(8'h00, mkCtrl(0, 1, 4'd0, 0, 2'd0, 5'd8, 1, 0, 1'b0, 1'b0));
    rd(8'h00, v); check(v[16] == 1'b1 && irq, "R8 zero write keeps flag", v[16], 1);
    wr(8'h00, mkCtrl(0, 1, 4'd0, 0, 2'd0, 5'd8, 1, 0, 1'b1, 1'b0));
    rd(8'h00, v); check(v[16] == 1'b0, "R8 flag cleared", v[16], 0);
    check(irq == 1'b0, "R8 irq dropped", irq, 0);

    runXfer(1, 0, 4'd0, 1, 2'd0, 5'd0,  0, 1, 16'd0, 32'hDEAD_BEEF, 32'h1357_9BDF, 0);
    runXfer(0, 1, 4'd2, 0, 2'd3, 5'd1,  0, 0, 16'd2, 32'h0000_0001, 32'h0000_0001, 0);
    runXfer(1, 1, 4'd1, 0, 2'd1, 5'd16, 1, 1, 16'd3, 32'h0000_C3A1, 32'h0000_5AF0, 1);

    // Constrained random transfers
    for (int i = 0; i < 8; i++) begin
      runXfer(1'($urandom), 1'($urandom), 4'($urandom_range(0, 3)), 1'($urandom),
              2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
              16'($urandom_range(0, 3)), $urandom, $urandom, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule